// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filter and Control-Character Flag

This block takes an asynchronous serial line and turns it into a stream of characters with status bits. A 16x tick from outside sets the bit rate: each bit spans sixteen ticks. The line is resynchronised, and a start bit is confirmed at its midpoint before any data is taken. The block then samples 5 to 9 data bits, least significant first. An optional parity bit and one stop bit follow. Each finished character is packed with its parity-error and framing-error bits and written into a receive queue of up to four entries.

The host sets the character length, parity, the usable queue depth and a fill threshold. In 9-bit mode the ninth bit marks a character as an address. When filtering is on, the block keeps only those characters that follow an address equal to a programmed value. A level flag reports whether the last completed character equalled a programmed control value. An echo mode copies the line straight to the transmit output. A loopback mode feeds the local transmitter's line into the receiver and holds the transmit output at mark.

The host reads the queue through a valid/ready stream. `m_valid` is high while the queue holds an entry, and `m_data` shows the oldest one. An entry leaves the queue on each clock edge where both `m_valid` and `m_ready` are high. While `m_ready` is low, `m_data` and `m_valid` hold steady. The receive side cannot be stalled. A character that finds the queue at its configured depth is lost and sets a sticky overrun flag.

Top module: `serial_rx_matcher`

## Requirements
- R1: A low line seen on a tick opens a start bit. The start bit is taken only if the line is still low at the 8th following tick; otherwise the receiver goes back to idle and stores nothing.
- R2: Data bits are taken at mid-bit, least significant first. `cfg_bits` sets the count; values below 5 act as 5 and values above 9 act as 9. Entry bits [8:0] hold the data, and the bits above the length are zero.
- R3: With `cfg_par_en`=1, one parity bit follows the data. Even parity is `cfg_par_odd`=0 and odd parity is 1. A mismatch sets entry bit [9].
- R4: A low stop-bit sample sets entry bit [10]. The character is still stored.
- R5: The usable depth is `cfg_depth`, with 0 acting as 1 and values above 4 acting as 4. A character that completes while the fill level is at or above that depth is dropped, and `overrun` then stays high until reset. The comparison uses the fill level before any pop in the same cycle.
- R6: `thresh_hit` is high while the fill level is at or above `cfg_thresh`, with 0 acting as 1.
- R7: `m_valid` is high while the queue is non-empty, and `m_data` shows the oldest entry. An entry is popped on an edge with `m_valid` and `m_ready` both high. While `m_ready` is low, `m_valid` and `m_data` hold.
- R8: Filtering applies when the length is 9 and `cfg_addr_en`=1. An address character (bit [8]=1) is stored and sets `addressed` if bits [7:0] equal `cfg_addr`. Otherwise it is dropped and `addressed` clears. Data characters (bit [8]=0) are stored only while `addressed` is high. `addressed` is low after reset.
- R9: `ctrl_seen` is updated on every character that passes the address filter. It becomes 1 if the 9-bit data field equals `cfg_ctrl` and 0 if it does not.
- R10: With `cfg_echo`=1 and `cfg_loop`=0, `txd_out` follows `rxd` combinationally. With both at 0, it follows `lb_txd`.
- R11: With `cfg_loop`=1, the receiver takes `lb_txd` in place of `rxd`, and `txd_out` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial line in |
| lb_txd | input | 1 | Local transmitter line |
| txd_out | output | 1 | Transmit line after echo/loop selection |
| cfg_bits | input | 4 | Data bits per character (5..9) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_depth | input | 3 | Usable queue depth (1..4) |
| cfg_thresh | input | 3 | Fill threshold (1..4) |
| cfg_addr_en | input | 1 | Address filter enable (9-bit mode) |
| cfg_addr | input | 8 | Station address |
| cfg_ctrl | input | 9 | Control value to detect |
| cfg_echo | input | 1 | Echo line to transmit output |
| cfg_loop | input | 1 | Loopback |
| m_valid | output | 1 | Queue entry available |
| m_ready | input | 1 | Host takes entry |
| m_data | output | 11 | {frame err, parity err, data[8:0]} |
| thresh_hit | output | 1 | Fill level at or above threshold |
| addressed | output | 1 | Last address character matched |
| ctrl_seen | output | 1 | Last accepted character equalled control value |
| overrun | output | 1 | Sticky character-lost flag |

## Verification
The bench sends a low glitch shorter than half a bit. A receiver that skipped the mid-start check would store a garbage character. It sends characters with a deliberately wrong parity bit and with a low stop bit. Swapped parity sense or a lost error bit shows up in bits [10:9] of the entry. With the depth set to two, it sends three characters. A queue that ignored the programmed depth would hold the third character, and one that overwrote would lose the first. In 9-bit filtered mode, it sends data before any address, after a matching address and after a foreign address. A filter that kept its state wrongly would let the wrong data through or block the wanted data.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int RX_DEPTH   = 4;
  localparam int RX_MAXBITS = 9;
  localparam int RX_OSR     = 16;
  localparam int RX_LENW    = $clog2(RX_MAXBITS + 1);
  localparam int RX_ENTW    = RX_MAXBITS + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int OSR     = RX_OSR,
  parameter int MAXBITS = RX_MAXBITS,
  parameter int LENW    = RX_LENW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rx,
  input  logic [LENW-1:0]    nbits,
  input  logic               par_en,
  input  logic               par_odd,
  output logic               done,
  output logic [MAXBITS-1:0] data,
  output logic               pe,
  output logic               fe
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [LENW-1:0] idx;
  logic            pbit;
  logic            bit_end;

  assign bit_end = tick && (cnt == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      idx  <= '0;
      data <= '0;
      pbit <= 1'b0;
      done <= 1'b0;
      pe   <= 1'b0;
      fe   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (tick && !rx) begin
          st  <= ST_START;
          cnt <= '0;
        end
        ST_START: if (tick) begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            if (!rx) begin
              st   <= ST_DATA;
              idx  <= '0;
              data <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: if (tick) begin
          cnt <= cnt + 1'b1;
          if (bit_end) begin
            data[idx] <= rx;
            idx <= idx + 1'b1;
            if (idx == nbits - 1'b1) st <= par_en ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: if (tick) begin
          cnt <= cnt + 1'b1;
          if (bit_end) begin
            pbit <= rx;
            st   <= ST_STOP;
          end
        end
        ST_STOP: if (tick) begin
          cnt <= cnt + 1'b1;
          if (bit_end) begin
            done <= 1'b1;
            fe   <= !rx;
            pe   <= par_en & (^data ^ pbit ^ par_odd);
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: a start bit that is high again at its midpoint goes back to idle
  p_false_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && tick && cnt == CW'(HALF - 1) && rx) |=> (st == ST_IDLE && !done));

  // R4: a character can only complete out of the stop state
  p_done_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st) == ST_STOP);
endmodule

// File: rtl/srx_filter.sv
module srx_filter
  import srx_pkg::*;
#(
  parameter int MAXBITS = RX_MAXBITS,
  parameter int ENTW    = RX_ENTW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done,
  input  logic [MAXBITS-1:0] data,
  input  logic               pe,
  input  logic               fe,
  input  logic               nine,
  input  logic               addr_en,
  input  logic [MAXBITS-2:0] addr,
  input  logic [MAXBITS-1:0] ctrl,
  output logic               push,
  output logic [ENTW-1:0]    entry,
  output logic               addressed,
  output logic               ctrl_seen
);
  logic filt, is_addr, hit, keep;

  always_comb begin
    filt    = addr_en && nine;
    is_addr = data[MAXBITS-1];
    hit     = (data[MAXBITS-2:0] == addr);
    if (!filt)        keep = 1'b1;
    else if (is_addr) keep = hit;
    else              keep = addressed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push      <= 1'b0;
      entry     <= '0;
      addressed <= 1'b0;
      ctrl_seen <= 1'b0;
    end else begin
      push <= 1'b0;
      if (done) begin
        push  <= keep;
        entry <= {fe, pe, data};
        if (filt && is_addr) addressed <= hit;
        if (keep) ctrl_seen <= (data == ctrl);
      end
    end
  end

  // R8: a data character arriving while not addressed is never forwarded
  p_drop_unaddressed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && addr_en && nine && !data[MAXBITS-1] && !addressed) |=> !push);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = RX_DEPTH,
  parameter int W     = RX_ENTW,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic [CNTW-1:0] cfg_depth,
  input  logic [CNTW-1:0] cfg_thresh,
  output logic            valid,
  input  logic            ready,
  output logic [W-1:0]    dout,
  output logic            thresh_hit,
  output logic            overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   rd, wr;
  logic [CNTW-1:0] count, eff_depth, eff_th;
  logic            full, pop, wr_en;

  function automatic logic [CNTW-1:0] clamp(input logic [CNTW-1:0] v);
    if (v == '0) return CNTW'(1);
    if (v > CNTW'(DEPTH)) return CNTW'(DEPTH);
    return v;
  endfunction

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign eff_depth  = clamp(cfg_depth);
  assign eff_th     = clamp(cfg_thresh);
  assign full       = (count >= eff_depth);
  assign valid      = (count != '0);
  assign pop        = valid && ready;
  assign wr_en      = push && !full;
  assign dout       = mem[rd];
  assign thresh_hit = (count >= eff_th);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd      <= '0;
      wr      <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_en) wr <= nxt(wr);
      if (pop)   rd <= nxt(rd);
      count <= count + CNTW'(wr_en) - CNTW'(pop);
      if (push && full) overrun <= 1'b1;
    end
  end

  // R5: a push into a full queue does not change the fill level
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> count == $past(count));

  // R5: a lost character leaves overrun set
  p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overrun);

  // R7: output held while the host withholds ready
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));

  // R6: threshold is at least one, so it implies a non-empty queue
  p_thresh_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_hit |-> valid);
endmodule

// File: rtl/serial_rx_matcher.sv
module serial_rx_matcher
  import srx_pkg::*;
#(
  parameter int DEPTH   = RX_DEPTH,
  parameter int OSR     = RX_OSR,
  parameter int MAXBITS = RX_MAXBITS,
  parameter int LENW    = $clog2(MAXBITS + 1),
  parameter int CNTW    = $clog2(DEPTH + 1),
  parameter int ENTW    = MAXBITS + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick16,
  input  logic               rxd,
  input  logic               lb_txd,
  output logic               txd_out,
  input  logic [LENW-1:0]    cfg_bits,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  input  logic [CNTW-1:0]    cfg_depth,
  input  logic [CNTW-1:0]    cfg_thresh,
  input  logic               cfg_addr_en,
  input  logic [MAXBITS-2:0] cfg_addr,
  input  logic [MAXBITS-1:0] cfg_ctrl,
  input  logic               cfg_echo,
  input  logic               cfg_loop,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [ENTW-1:0]    m_data,
  output logic               thresh_hit,
  output logic               addressed,
  output logic               ctrl_seen,
  output logic               overrun
);
  localparam int MINBITS = 5;

  logic [1:0]         sync;
  logic               rx_s;
  logic [LENW-1:0]    nbits;
  logic               done, pe, fe, push;
  logic [MAXBITS-1:0] cdata;
  logic [ENTW-1:0]    entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[0], cfg_loop ? lb_txd : rxd};
  end
  assign rx_s = sync[1];

  assign txd_out = cfg_loop ? 1'b1 : (cfg_echo ? rxd : lb_txd);

  always_comb begin
    if (cfg_bits < LENW'(MINBITS))      nbits = LENW'(MINBITS);
    else if (cfg_bits > LENW'(MAXBITS)) nbits = LENW'(MAXBITS);
    else                                nbits = cfg_bits;
  end

  srx_sampler #(.OSR(OSR), .MAXBITS(MAXBITS), .LENW(LENW)) u_samp (
    .clk, .rst_n, .tick(tick16), .rx(rx_s), .nbits,
    .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .done, .data(cdata), .pe, .fe
  );

  srx_filter #(.MAXBITS(MAXBITS), .ENTW(ENTW)) u_filt (
    .clk, .rst_n, .done, .data(cdata), .pe, .fe,
    .nine(nbits == LENW'(MAXBITS)), .addr_en(cfg_addr_en),
    .addr(cfg_addr), .ctrl(cfg_ctrl),
    .push, .entry, .addressed, .ctrl_seen
  );

  srx_fifo #(.DEPTH(DEPTH), .W(ENTW), .CNTW(CNTW)) u_fifo (
    .clk, .rst_n, .push, .din(entry),
    .cfg_depth, .cfg_thresh,
    .valid(m_valid), .ready(m_ready), .dout(m_data),
    .thresh_hit, .overrun
  );

  // R11: loopback keeps the transmit line at mark
  p_loop_mark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loop |-> txd_out);
endmodule

// File: tb/test_serial_rx_matcher.sv
module test_serial_rx_matcher;
  localparam int BIT = 32;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic        line = 1, use_lb = 0, tx_drv = 1;
  logic        rxd, lb_txd, txd_out;
  logic [3:0]  cfg_bits = 8;
  logic        cfg_par_en = 0, cfg_par_odd = 0;
  logic [2:0]  cfg_depth = 4, cfg_thresh = 1;
  logic        cfg_addr_en = 0, cfg_echo = 0, cfg_loop = 0;
  logic [7:0]  cfg_addr = 0;
  logic [8:0]  cfg_ctrl = 9'h1FF;
  logic        m_valid, m_ready = 0;
  logic [10:0] m_data;
  logic        thresh_hit, addressed, ctrl_seen, overrun;
  int total = 0, bad = 0;

  assign rxd    = use_lb ? 1'b1 : line;
  assign lb_txd = use_lb ? line : tx_drv;

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  serial_rx_matcher i_serial_rx_matcher (
    .clk, .rst_n, .tick16(tick), .rxd, .lb_txd, .txd_out,
    .cfg_bits, .cfg_par_en, .cfg_par_odd, .cfg_depth, .cfg_thresh,
    .cfg_addr_en, .cfg_addr, .cfg_ctrl, .cfg_echo, .cfg_loop,
    .m_valid, .m_ready, .m_data, .thresh_hit, .addressed, .ctrl_seen, .overrun
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    wait_clk(4);
    rst_n = 1;
    wait_clk(4);
  endtask

  task automatic send(input logic [8:0] d, input int n, input bit bad_par, input bit stop_hi);
    bit p = 0;
    line = 0;
    wait_clk(BIT);
    for (int i = 0; i < n; i++) begin
      line = d[i];
      p ^= d[i];
      wait_clk(BIT);
    end
    if (cfg_par_en) begin
      line = p ^ cfg_par_odd ^ bad_par;
      wait_clk(BIT);
    end
    line = stop_hi;
    wait_clk(stop_hi ? BIT : 20);
    line = 1;
    wait_clk(2 * BIT);
  endtask

  task automatic pop_chk(input string req, input logic [10:0] exp);
    int n = 0;
    while (!m_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " valid"}, m_valid, 1);
    chk({req, " data"}, m_data, exp);
    m_ready = 1;
    @(negedge clk);
    m_ready = 0;
  endtask

  task automatic t_reset();
    chk("R7 reset valid", m_valid, 0);
    chk("R5 reset overrun", overrun, 0);
    chk("R6 reset thresh", thresh_hit, 0);
    chk("R8 reset addressed", addressed, 0);
    chk("R10 reset txd", txd_out, 1);
  endtask

  task automatic t_basic();
    cfg_bits = 8;
    send(9'h0A5, 8, 0, 1);
    pop_chk("R2 8-bit", 11'h0A5);
    cfg_bits = 5;
    send(9'h015, 5, 0, 1);
    pop_chk("R2 5-bit", 11'h015);
    cfg_bits = 2;
    send(9'h00B, 5, 0, 1);
    pop_chk("R2 short length acts as 5", 11'h00B);
    cfg_bits = 8;
  endtask

  task automatic t_parity();
    cfg_bits = 7; cfg_par_en = 1; cfg_par_odd = 0;
    send(9'h035, 7, 0, 1);
    pop_chk("R3 even ok", 11'h035);
    send(9'h035, 7, 1, 1);
    pop_chk("R3 even bad", 11'h235);
    cfg_bits = 8; cfg_par_odd = 1;
    send(9'h007, 8, 0, 1);
    pop_chk("R3 odd ok", 11'h007);
    send(9'h007, 8, 1, 1);
    pop_chk("R3 odd bad", 11'h207);
    cfg_par_en = 0; cfg_par_odd = 0;
  endtask

  task automatic t_frame();
    send(9'h03C, 8, 0, 0);
    pop_chk("R4 framing", 11'h43C);
    wait_clk(4 * BIT);
    chk("R4 no ghost after frame error", m_valid, 0);
  endtask

  task automatic t_false_start();
    line = 0;
    wait_clk(8);
    line = 1;
    wait_clk(12 * BIT);
    chk("R1 glitch rejected", m_valid, 0);
    send(9'h0C3, 8, 0, 1);
    pop_chk("R1 receive after glitch", 11'h0C3);
  endtask

  task automatic t_thresh();
    cfg_thresh = 2;
    send(9'h011, 8, 0, 1);
    chk("R6 below thresh", thresh_hit, 0);
    send(9'h022, 8, 0, 1);
    chk("R6 at thresh", thresh_hit, 1);
    pop_chk("R6 pop1", 11'h011);
    chk("R6 below after pop", thresh_hit, 0);
    pop_chk("R6 pop2", 11'h022);
    cfg_thresh = 1;
  endtask

  task automatic t_backpressure();
    send(9'h05A, 8, 0, 1);
    send(9'h0A6, 8, 0, 1);
    wait_clk(10);
    chk("R7 held valid", m_valid, 1);
    chk("R7 held data", m_data, 11'h05A);
    pop_chk("R7 first", 11'h05A);
    pop_chk("R7 second", 11'h0A6);
    chk("R7 empty", m_valid, 0);
  endtask

  task automatic t_overrun();
    cfg_depth = 2;
    send(9'h001, 8, 0, 1);
    send(9'h002, 8, 0, 1);
    chk("R5 no overrun yet", overrun, 0);
    send(9'h003, 8, 0, 1);
    chk("R5 overrun set", overrun, 1);
    pop_chk("R5 keep first", 11'h001);
    pop_chk("R5 keep second", 11'h002);
    chk("R5 third dropped", m_valid, 0);
    chk("R5 overrun sticky", overrun, 1);
    cfg_depth = 4;
    do_reset();
    chk("R5 overrun cleared by reset", overrun, 0);
  endtask

  task automatic t_addr();
    cfg_bits = 9; cfg_addr_en = 1; cfg_addr = 8'h5A;
    send(9'h011, 9, 0, 1);
    chk("R8 data before address dropped", m_valid, 0);
    send(9'h1A5, 9, 0, 1);
    chk("R8 foreign address dropped", m_valid, 0);
    chk("R8 not addressed", addressed, 0);
    send(9'h15A, 9, 0, 1);
    chk("R8 addressed", addressed, 1);
    send(9'h022, 9, 0, 1);
    pop_chk("R8 own address stored", 11'h15A);
    pop_chk("R8 data stored", 11'h022);
    send(9'h133, 9, 0, 1);
    send(9'h044, 9, 0, 1);
    chk("R8 deselected", addressed, 0);
    chk("R8 data after foreign dropped", m_valid, 0);
    cfg_addr_en = 0; cfg_bits = 8;
  endtask

  task automatic t_ctrl();
    cfg_ctrl = 9'h00D;
    send(9'h00D, 8, 0, 1);
    chk("R9 control seen", ctrl_seen, 1);
    send(9'h041, 8, 0, 1);
    chk("R9 control cleared", ctrl_seen, 0);
    pop_chk("R9 pop a", 11'h00D);
    pop_chk("R9 pop b", 11'h041);
  endtask

  task automatic t_echo();
    tx_drv = 0;
    wait_clk(1);
    chk("R10 pass transmitter", txd_out, 0);
    tx_drv = 1;
    cfg_echo = 1;
    line = 0;
    wait_clk(1);
    chk("R10 echo low", txd_out, 0);
    line = 1;
    wait_clk(1);
    chk("R10 echo high", txd_out, 1);
    cfg_echo = 0;
    wait_clk(2 * BIT);
  endtask

  task automatic t_loop();
    cfg_loop = 1; use_lb = 1;
    wait_clk(4);
    line = 0;
    wait_clk(1);
    chk("R11 mark during loop", txd_out, 1);
    line = 1;
    wait_clk(2 * BIT);
    while (m_valid) begin
      m_ready = 1;
      @(negedge clk);
      m_ready = 0;
    end
    send(9'h05B, 8, 0, 1);
    pop_chk("R11 loop data", 11'h05B);
    cfg_loop = 0; use_lb = 0;
    wait_clk(4);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1;
    wait_clk(4);
    t_basic();
    t_parity();
    t_frame();
    t_false_start();
    t_thresh();
    t_backpressure();
    t_overrun();
    t_addr();
    t_ctrl();
    t_echo();
    t_loop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule